// File: doc/BRIEF.md
# Grouped Interrupt Combiner

The combiner folds a wide vector of level-sensitive interrupt sources into a narrow set of parent interrupt lines. Sources come in groups of eight; every group owns one parent line that is high while any of its enabled sources is asserted. Each source passes through a two-flop synchroniser. A source is pending when its synchronised level is high and its enable bit is set.

Software sees the enables and the pending state through a flat register bus. The bus has a combinational read port and a single-cycle write strobe. Four groups are packed into one 32-bit bank, and the banks sit every 0x10 bytes. Group k lives in bank k/4, in bits [8*(k mod 4)+7 : 8*(k mod 4)]. Inside a bank there are three registers:

- Offset 0x0: a write-one-to-set enable register that also reads back the enable word. Software can therefore save the enables and restore them later.
- Offset 0x4: a write-one-to-clear enable register.
- Offset 0xC: a read-only pending word.

The number of groups is a parameter (default 20 groups, 160 sources, 5 banks).

Top module: `irq_combiner`

## Requirements
- R1: After reset every enable bit is 0, every group output is 0, and every register reads 0.
- R2: A write at bank offset 0x0 sets each enable bit whose write-data bit is 1. Enable bits whose write-data bit is 0 keep their value.
- R3: A write at bank offset 0x4 clears each enable bit whose write-data bit is 1. Enable bits whose write-data bit is 0 keep their value.
- R4: A read at bank offset 0x0 returns the bank's 32-bit enable word. A write takes effect in the readback one clock after the write edge.
- R5: A read at bank offset 0xC returns the synchronised input level ANDed with the enable word. Source s of group k appears at bit 8*(k mod 4)+(s mod 8) of bank k/4, at byte address 0x10*(k/4)+0xC.
- R6: Each group output is the registered OR of its eight pending bits. It changes three clock edges after an input change (two synchroniser stages plus the output register). It changes one edge after the enable bit has changed.
- R7: Outputs are level-sensitive: a group output stays high for as long as an enabled source of that group is held high, and falls once no enabled source is high.
- R8: Reads at offsets 0x4, 0x8 and the remaining unused offsets return 0. A bank index at or above the bank count also reads 0. Writes to those places and writes to offset 0xC change no enable bit.
- R9: In the last bank, bits belonging to groups beyond the group count always read 0 and cannot be set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_in | input | 8*N_GROUPS | Raw level-sensitive interrupt sources |
| bus_addr | input | ADDR_W | Byte address of the register access |
| bus_wr | input | 1 | Write strobe, one access per cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| grp_irq | output | N_GROUPS | One registered parent interrupt line per group |

## Verification
The bench builds the block with six groups and an 8-bit address. This gives two banks, the second holding only two groups. The upper half of that bank then tests that absent-group bits never set and never read back (R9). The 8-bit address also leaves bank indices 2 and up free, so accesses to a bank that does not exist can be tested. A small group count keeps the source vector at 48 bits, so random input patterns reach every pending bit and every group line within a few hundred cycles.

// File: rtl/irq_comb_pkg.sv
package irq_comb_pkg;
    localparam int GRP_W     = 8;
    localparam int BANK_GRPS = 4;
    localparam int WORD_W    = GRP_W * BANK_GRPS;
    localparam int OFF_W     = 4;

    typedef enum logic [OFF_W-1:0] {
        REG_EN_SET  = 4'h0,
        REG_EN_CLR  = 4'h4,
        REG_PENDING = 4'hC
    } reg_off_e;

    function automatic logic [WORD_W-1:0] bank_mask(input int n_groups, input int bank);
        int left;
        left = n_groups - BANK_GRPS * bank;
        if (left >= BANK_GRPS) return '1;
        if (left <= 0) return '0;
        return (WORD_W'(1) << (GRP_W * left)) - WORD_W'(1);
    endfunction
endpackage

// File: rtl/irq_comb_sync.sv
module irq_comb_sync #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1 <= '0;
            q      <= '0;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end
endmodule

// File: rtl/irq_comb_bank.sv
module irq_comb_bank
    import irq_comb_pkg::*;
#(
    parameter int BANK_IDX = 0,
    parameter int N_GROUPS = 20
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [WORD_W-1:0]    lvl,
    input  logic                 set_we,
    input  logic                 clr_we,
    input  logic [WORD_W-1:0]    wdata,
    output logic [WORD_W-1:0]    en_q,
    output logic [WORD_W-1:0]    pending,
    output logic [BANK_GRPS-1:0] grp_q
);
    localparam logic [WORD_W-1:0] VALID = bank_mask(N_GROUPS, BANK_IDX);

    logic [WORD_W-1:0] en_d;

    always_comb begin
        en_d = en_q;
        if (set_we) en_d = en_d | wdata;
        if (clr_we) en_d = en_d & ~wdata;
        en_d = en_d & VALID;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) en_q <= '0;
        else        en_q <= en_d;
    end

    assign pending = lvl & en_q;

    for (genvar k = 0; k < BANK_GRPS; k++) begin : g_grp
        always_ff @(posedge clk) begin
            if (!rst_n) grp_q[k] <= 1'b0;
            else        grp_q[k] <= |pending[GRP_W*k +: GRP_W];
        end
    end

    p_absent_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (en_q & ~VALID) == '0);

    p_set_hits_r2: assert property (@(posedge clk) disable iff (!rst_n)
        set_we |=> ((en_q & $past(wdata) & VALID) == ($past(wdata) & VALID)));

    p_set_keeps_r2: assert property (@(posedge clk) disable iff (!rst_n)
        set_we |=> ((en_q & ~$past(wdata)) == ($past(en_q) & ~$past(wdata))));

    p_clr_hits_r3: assert property (@(posedge clk) disable iff (!rst_n)
        clr_we |=> ((en_q & $past(wdata)) == '0));

    p_idle_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(set_we || clr_we) |=> $stable(en_q));
endmodule

// File: rtl/irq_combiner.sv
module irq_combiner
    import irq_comb_pkg::*;
#(
    parameter int N_GROUPS = 20,
    parameter int ADDR_W   = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [N_GROUPS*GRP_W-1:0] src_in,
    input  logic [ADDR_W-1:0]         bus_addr,
    input  logic                      bus_wr,
    input  logic [WORD_W-1:0]         bus_wdata,
    output logic [WORD_W-1:0]         bus_rdata,
    output logic [N_GROUPS-1:0]       grp_irq
);
    localparam int N_SRC   = N_GROUPS * GRP_W;
    localparam int N_BANKS = (N_GROUPS + BANK_GRPS - 1) / BANK_GRPS;
    localparam int PAD_W   = N_BANKS * WORD_W;
    localparam int BSEL_W  = ADDR_W - OFF_W;

    logic [N_SRC-1:0]           src_s;
    logic [PAD_W-1:0]           lvl_pad;
    logic [BSEL_W-1:0]          bsel;
    logic [OFF_W-1:0]           off;
    logic [WORD_W-1:0]          en_all  [N_BANKS];
    logic [WORD_W-1:0]          pend_all[N_BANKS];
    logic [N_BANKS*BANK_GRPS-1:0] grp_all;

    irq_comb_sync #(.W(N_SRC)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (src_in),
        .q     (src_s)
    );

    assign lvl_pad = PAD_W'(src_s);
    assign bsel    = bus_addr[ADDR_W-1:OFF_W];
    assign off     = bus_addr[OFF_W-1:0];

    for (genvar b = 0; b < N_BANKS; b++) begin : g_bank
        logic hit;
        assign hit = bus_wr && (bsel == BSEL_W'(b));

        irq_comb_bank #(.BANK_IDX(b), .N_GROUPS(N_GROUPS)) u_bank (
            .clk     (clk),
            .rst_n   (rst_n),
            .lvl     (lvl_pad[WORD_W*b +: WORD_W]),
            .set_we  (hit && (off == REG_EN_SET)),
            .clr_we  (hit && (off == REG_EN_CLR)),
            .wdata   (bus_wdata),
            .en_q    (en_all[b]),
            .pending (pend_all[b]),
            .grp_q   (grp_all[BANK_GRPS*b +: BANK_GRPS])
        );
    end

    always_comb begin
        bus_rdata = '0;
        for (int b = 0; b < N_BANKS; b++) begin
            if (bsel == BSEL_W'(b)) begin
                case (off)
                    REG_EN_SET:  bus_rdata = en_all[b];
                    REG_PENDING: bus_rdata = pend_all[b];
                    default:     bus_rdata = '0;
                endcase
            end
        end
    end

    assign grp_irq = grp_all[N_GROUPS-1:0];

    p_unmapped_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (off == 4'h4 || off == 4'h8 || bsel >= BSEL_W'(N_BANKS)) |-> (bus_rdata == '0));
endmodule

// File: tb/irq_combiner_tb_top.sv
module irq_combiner_tb_top;
    localparam int NG = 6;
    localparam int NS = NG * 8;
    localparam int NB = (NG + 3) / 4;
    localparam int AW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NS-1:0] src = '0;
    logic [AW-1:0] addr = '0;
    logic          wr = 1'b0;
    logic [31:0]   wdata = '0;
    logic [31:0]   rdata;
    logic [NG-1:0] grp;

    always #4 clk = ~clk;

    irq_combiner #(.N_GROUPS(NG), .ADDR_W(AW)) dut_i (
        .clk(clk), .rst_n(rst_n), .src_in(src), .bus_addr(addr),
        .bus_wr(wr), .bus_wdata(wdata), .bus_rdata(rdata), .grp_irq(grp)
    );

    int    n_chk = 0;
    int    n_fail = 0;
    string cur = "R1";

    logic [31:0]   m_en[NB];
    logic [NS-1:0] m_s1, m_s2;
    logic [NG-1:0] m_grp;

    function automatic logic [31:0] vmask(int b);
        int left = NG - 4 * b;
        if (left >= 4) return 32'hFFFF_FFFF;
        return (32'h1 << (8 * left)) - 32'h1;
    endfunction

    function automatic logic [31:0] lvl_word(int b);
        logic [31:0] w = '0;
        for (int i = 0; i < 32; i++)
            if (32 * b + i < NS) w[i] = m_s2[32 * b + i];
        return w;
    endfunction

    function automatic logic [31:0] exp_rd(logic [AW-1:0] a);
        int b = int'(a[AW-1:4]);
        if (b >= NB) return 32'h0;
        case (a[3:0])
            4'h0:    return m_en[b];
            4'hC:    return m_en[b] & lvl_word(b);
            default: return 32'h0;
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int b = 0; b < NB; b++) m_en[b] <= '0;
            m_s1  <= '0;
            m_s2  <= '0;
            m_grp <= '0;
        end else begin
            for (int g = 0; g < NG; g++)
                m_grp[g] <= |(m_en[g / 4][8 * (g % 4) +: 8] & m_s2[8 * g +: 8]);
            if (wr && int'(addr[AW-1:4]) < NB) begin
                if (addr[3:0] == 4'h0)
                    m_en[int'(addr[AW-1:4])] <= (m_en[int'(addr[AW-1:4])] | wdata) & vmask(int'(addr[AW-1:4]));
                else if (addr[3:0] == 4'h4)
                    m_en[int'(addr[AW-1:4])] <= m_en[int'(addr[AW-1:4])] & ~wdata;
            end
            m_s2 <= m_s1;
            m_s1 <= src;
        end
    end

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n) begin
            chk({cur, " model grp"}, 32'(grp), 32'(m_grp));
            chk({cur, " model rdata"}, rdata, exp_rd(addr));
        end
    end

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic bus_write(logic [AW-1:0] a, logic [31:0] d);
        tick();
        addr = a; wdata = d; wr = 1'b1;
        tick();
        wr = 1'b0;
    endtask

    task automatic peek(string req, logic [AW-1:0] a, logic [31:0] exp);
        tick();
        addr = a;
        #1;
        chk(req, rdata, exp);
    endtask

    task automatic gchk(string req, logic [31:0] exp);
        #1;
        chk(req, 32'(grp), exp);
    endtask

    task automatic set_src(int i, logic v);
        tick();
        src[i] = v;
    endtask

    initial begin
        #(8 * 150000);
        n_fail++;
        $display("FAIL watchdog R1: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (4) @(posedge clk);
        #2 rst_n = 1'b1;
        cur = "R1";
        gchk("R1 grp after reset", 32'h0);
        peek("R1 bank0 enables", 8'h00, 32'h0);
        peek("R1 bank1 enables", 8'h10, 32'h0);

        cur = "R2";
        bus_write(8'h00, 32'h0000_00FF);
        peek("R2 R4 set low byte", 8'h00, 32'h0000_00FF);
        bus_write(8'h00, 32'h0000_FF00);
        peek("R2 zeros keep", 8'h00, 32'h0000_FFFF);

        cur = "R3";
        bus_write(8'h04, 32'h0000_000F);
        peek("R3 clear nibble", 8'h00, 32'h0000_FFF0);
        peek("R8 read offset 4", 8'h04, 32'h0);

        cur = "R6";
        set_src(4, 1'b1);
        tick(); gchk("R6 edge1", 32'h0);
        tick(); gchk("R6 edge2", 32'h0);
        tick(); gchk("R6 edge3", 32'h1);
        peek("R5 pending bit4", 8'h0C, 32'h0000_0010);

        cur = "R7";
        for (int i = 0; i < 20; i++) begin
            tick(); gchk("R7 held", 32'h1);
        end
        set_src(4, 1'b0);
        tick(); gchk("R7 fall edge1", 32'h1);
        tick(); gchk("R7 fall edge2", 32'h1);
        tick(); gchk("R7 fall edge3", 32'h0);

        cur = "R5";
        set_src(0, 1'b1);
        repeat (4) tick();
        gchk("R5 disabled source", 32'h0);
        peek("R5 disabled pending", 8'h0C, 32'h0);
        cur = "R6";
        bus_write(8'h00, 32'h1);
        gchk("R6 enable edge0", 32'h0);
        tick(); gchk("R6 enable edge1", 32'h1);
        bus_write(8'h04, 32'h1);
        gchk("R6 disable edge0", 32'h1);
        tick(); gchk("R6 disable edge1", 32'h0);
        set_src(0, 1'b0);

        cur = "R9";
        bus_write(8'h10, 32'hFFFF_FFFF);
        peek("R9 absent groups masked", 8'h10, 32'h0000_FFFF);
        set_src(40, 1'b1);
        repeat (3) tick();
        peek("R5 group5 mapping", 8'h1C, 32'h0000_0100);
        gchk("R5 group5 line", 32'h20);

        cur = "R8";
        bus_write(8'h08, 32'hFFFF_FFFF);
        bus_write(8'h0C, 32'hFFFF_FFFF);
        bus_write(8'h20, 32'hFFFF_FFFF);
        bus_write(8'h24, 32'hFFFF_FFFF);
        peek("R8 bank0 untouched", 8'h00, 32'h0000_FFF0);
        peek("R8 bank1 untouched", 8'h10, 32'h0000_FFFF);
        peek("R8 absent bank reads 0", 8'h20, 32'h0);
        peek("R8 offset 8 reads 0", 8'h18, 32'h0);
        set_src(40, 1'b0);

        cur = "R4";
        for (int i = 0; i < 400; i++) begin
            tick();
            src = NS'({$urandom, $urandom});
            addr = AW'($urandom_range(0, 47));
            wdata = $urandom;
            wr = ($urandom_range(0, 3) == 0);
        end
        tick();
        wr = 1'b0;
        repeat (5) tick();

        $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end
endmodule